// File: doc/BRIEF.md
# Burst-of-Two Split-Port SRAM Core

This block is a synthesizable model of a small static memory with a read port and a write port that work at the same time. Every access moves exactly two words, at address A and then at A+1. The two halves of each bus cycle are modelled as alternating edges of one double-rate clock. The first edge after reset is a "K" edge, the next is its complement (a "K#" edge), and so on. Commands, the read address and the first write beat enter on K edges. The write address and the second write beat enter on the K# edge that follows.

Write data is not put into the array at once. It waits in a posted-write buffer and reaches the array only when the next write completes. Reads always see the newest data. Data is merged byte by byte from the array, then the buffer, then a write still in flight. So a read issued at the same K edge as a write, or one K edge before it, to the same address returns the newly written bytes. Read beats leave through a fixed registered pipeline, and a valid flag marks each beat on the output.

Top module: `qb2_sram`

## Requirements
- R1: After reset is released, clock edges alternate K, K#, K, and so on, starting with K. The strobes `rd_n` and `wr_n` are sampled only on K edges; their levels on K# edges have no effect.
- R2: `rd_n` low on a K edge captures `addr` as read address A. The first beat (word A) is on `dout` with `dout_vld` high after the third edge following that command edge. The second beat (word A+1) follows after the fourth edge.
- R3: The second word of a burst is at address A+1 modulo the depth, for reads and for writes; the address after the last word is 0.
- R4: `wr_n` low on a K edge captures `din` and `bwe_n` as beat 0 on that edge. The next K# edge captures `addr` as write address W, together with `din` and `bwe_n` as beat 1.
- R5: Each beat is split into 9-bit bytes, with byte i in bits [9i+8:9i]. When `bwe_n[i]` is 0, that byte is written; when it is 1, the old contents of that byte stay. If all bits of `bwe_n` are 1, the beat leaves its word unchanged.
- R6: A completed write is held in a posted buffer and goes into the array only when the next write completes. Reads made after it completes return its data whether or not it has been committed yet.
- R7: A read at the same K edge as a write, or one K edge before it, returns the bytes of that write for every word the two bursts share.
- R8: The read and write paths work independently in the same cycle. A K edge with `rd_n` high does not cut short a burst already in flight. Reads on consecutive K edges give an unbroken run of beats.
- R9: When no beat is due, `dout_vld` is 0 and `dout` is all zeros; the output turns off on the edge after the second beat of the last read.
- R10: Reset clears the array and the posted buffer, sets `dout_vld` and `dout` to 0, and makes the next edge a K edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; its edges alternate between K and K# |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Read strobe, active low, sampled on K edges |
| wr_n | input | 1 | Write strobe, active low, sampled on K edges |
| addr | input | AW | Read address on K edges, write address on K# edges |
| din | input | BYTES*BYTE_W | Write data: beat 0 on K, beat 1 on K# |
| bwe_n | input | BYTES | Active-low byte write enables for the beat on `din` |
| dout | output | BYTES*BYTE_W | Read beat data, zero when idle |
| dout_vld | output | 1 | High while `dout` carries a read beat |

## Verification
The bench aims at the coherence windows. In one case a read is followed on the next K edge by a write to the same address: the first beat has to take beat 0 from the write still in flight, and a read of A+1 has to take beat 1 straight from the data input. A design that forwards too little would return stale data here. A design that forwards a write issued too late would return data that does not exist yet. The bench also sweeps every byte-enable mask on both beats and reads the words back. A byte swapped or a polarity inverted would show as a wrong byte in the result. It also checks that the burst wraps from the last address to 0, and that strobes held low on K# edges do nothing. Idle gaps between reads check that the output turns off on the correct edge and not a half-cycle early or late.

// File: rtl/qb2_pkg.sv
package qb2_pkg;
    // Which half of the bus cycle the next clock edge belongs to.
    typedef enum logic {
        PH_K  = 1'b0,
        PH_KB = 1'b1
    } phase_e;
endpackage

// File: rtl/qb2_merge.sv
// Byte-granular overlay: each enabled byte of upd_i replaces base_i when hit_i.
module qb2_merge #(
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic [BYTES*BYTE_W-1:0] base_i,
    input  logic [BYTES*BYTE_W-1:0] upd_i,
    input  logic [BYTES-1:0]        en_i,
    input  logic                    hit_i,
    output logic [BYTES*BYTE_W-1:0] res_o
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign res_o[b*BYTE_W +: BYTE_W] = (hit_i && en_i[b]) ? upd_i[b*BYTE_W +: BYTE_W]
                                                              : base_i[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/qb2_rd_pipe.sv
// Read request pipeline: a command on a K edge yields beat 0 three edges later
// and beat 1 four edges later.
module qb2_rd_pipe #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          k_edge,
    input  logic          rd_n,
    input  logic [AW-1:0] addr,
    output logic          b0_fire,
    output logic [AW-1:0] b0_addr,
    output logic          b1_fire,
    output logic [AW-1:0] b1_addr
);
    localparam int STAGES = 4;

    typedef struct packed {
        logic [STAGES-1:0]         v;
        logic [STAGES-1:0][AW-1:0] a;
    } rp_t;

    rp_t q, d;

    always_comb begin
        d   = q;
        d.v = {q.v[STAGES-2:0], k_edge & ~rd_n};
        d.a = {q.a[STAGES-2:0], addr};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign b0_fire = q.v[STAGES-2];
    assign b0_addr = q.a[STAGES-2];
    assign b1_fire = q.v[STAGES-1];
    assign b1_addr = q.a[STAGES-1] + 1'b1;
endmodule

// File: rtl/qb2_wbuf.sv
// Write capture across a K/K# pair plus the single-entry posted buffer.
module qb2_wbuf #(
    parameter int AW     = 4,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    k_edge,
    input  logic                    wr_n,
    input  logic [AW-1:0]           addr,
    input  logic [BYTES*BYTE_W-1:0] din,
    input  logic [BYTES-1:0]        bwe_n,
    output logic                    fl_v,
    output logic [BYTES*BYTE_W-1:0] fl_d0,
    output logic [BYTES-1:0]        fl_be0,
    output logic                    buf_v,
    output logic [AW-1:0]           buf_a,
    output logic [BYTES*BYTE_W-1:0] buf_d0,
    output logic [BYTES*BYTE_W-1:0] buf_d1,
    output logic [BYTES-1:0]        buf_be0,
    output logic [BYTES-1:0]        buf_be1,
    output logic                    commit
);
    localparam int W = BYTES * BYTE_W;

    typedef struct packed {
        logic             wip;
        logic [W-1:0]     wd0;
        logic [BYTES-1:0] wbe0;
        logic             bv;
        logic [AW-1:0]    ba;
        logic [W-1:0]     bd0;
        logic [W-1:0]     bd1;
        logic [BYTES-1:0] bbe0;
        logic [BYTES-1:0] bbe1;
    } wb_t;

    wb_t q, d;

    always_comb begin
        d = q;
        if (k_edge) begin
            d.wip  = ~wr_n;
            d.wd0  = din;
            d.wbe0 = ~bwe_n;
        end else if (q.wip) begin
            d.wip  = 1'b0;
            d.bv   = 1'b1;
            d.ba   = addr;
            d.bd0  = q.wd0;
            d.bbe0 = q.wbe0;
            d.bd1  = din;
            d.bbe1 = ~bwe_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fl_v    = ~k_edge & q.wip;
    assign fl_d0   = q.wd0;
    assign fl_be0  = q.wbe0;
    assign buf_v   = q.bv;
    assign buf_a   = q.ba;
    assign buf_d0  = q.bd0;
    assign buf_d1  = q.bd1;
    assign buf_be0 = q.bbe0;
    assign buf_be1 = q.bbe1;
    assign commit  = fl_v & q.bv;

    logic wr_cmd;
    assign wr_cmd = k_edge & ~wr_n;

    // R4
    wr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |-> ##2 buf_v);

    // R6
    buf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(buf_v));
endmodule

// File: rtl/qb2_sram.sv
// Burst-of-two split-port SRAM core with posted writes and byte-merged forwarding.
module qb2_sram #(
    parameter int AW     = 4,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic [AW-1:0]           addr,
    input  logic [BYTES*BYTE_W-1:0] din,
    input  logic [BYTES-1:0]        bwe_n,
    output logic [BYTES*BYTE_W-1:0] dout,
    output logic                    dout_vld
);
    import qb2_pkg::*;

    localparam int W     = BYTES * BYTE_W;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        phase_e                   ph;
        logic [DEPTH-1:0][W-1:0]  mem;
        logic                     dvld;
        logic [W-1:0]             dout;
    } top_t;

    top_t q, d;
    logic k_edge;
    assign k_edge = (q.ph == PH_K);

    // Read pipeline
    logic          b0_fire, b1_fire;
    logic [AW-1:0] b0_addr, b1_addr;

    qb2_rd_pipe #(.AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .rd_n(rd_n), .addr(addr),
        .b0_fire(b0_fire), .b0_addr(b0_addr), .b1_fire(b1_fire), .b1_addr(b1_addr)
    );

    // Write capture and posted buffer
    logic             fl_v, buf_v, commit;
    logic [W-1:0]     fl_d0, buf_d0, buf_d1;
    logic [BYTES-1:0] fl_be0, buf_be0, buf_be1;
    logic [AW-1:0]    buf_a;

    qb2_wbuf #(.AW(AW), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_wb (
        .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .wr_n(wr_n), .addr(addr),
        .din(din), .bwe_n(bwe_n),
        .fl_v(fl_v), .fl_d0(fl_d0), .fl_be0(fl_be0),
        .buf_v(buf_v), .buf_a(buf_a), .buf_d0(buf_d0), .buf_d1(buf_d1),
        .buf_be0(buf_be0), .buf_be1(buf_be1), .commit(commit)
    );

    // Forwarding chain: array, then posted buffer, then write in flight.
    logic          rv;
    logic [AW-1:0] ra, buf_a1, addr1;
    logic [W-1:0]  m1, m2, m3, m4, c0, c1;

    assign rv     = b0_fire | b1_fire;
    assign ra     = b0_fire ? b0_addr : b1_addr;
    assign buf_a1 = buf_a + 1'b1;
    assign addr1  = addr + 1'b1;

    qb2_merge #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_f0 (
        .base_i(q.mem[ra]), .upd_i(buf_d0), .en_i(buf_be0),
        .hit_i(buf_v && (ra == buf_a)), .res_o(m1));
    qb2_merge #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_f1 (
        .base_i(m1), .upd_i(buf_d1), .en_i(buf_be1),
        .hit_i(buf_v && (ra == buf_a1)), .res_o(m2));
    qb2_merge #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_f2 (
        .base_i(m2), .upd_i(fl_d0), .en_i(fl_be0),
        .hit_i(fl_v && (ra == addr)), .res_o(m3));
    qb2_merge #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_f3 (
        .base_i(m3), .upd_i(din), .en_i(~bwe_n),
        .hit_i(fl_v && (ra == addr1)), .res_o(m4));

    // Commit of the older buffered write into the array.
    qb2_merge #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_c0 (
        .base_i(q.mem[buf_a]), .upd_i(buf_d0), .en_i(buf_be0),
        .hit_i(1'b1), .res_o(c0));
    qb2_merge #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_c1 (
        .base_i(q.mem[buf_a1]), .upd_i(buf_d1), .en_i(buf_be1),
        .hit_i(1'b1), .res_o(c1));

    always_comb begin
        d    = q;
        d.ph = (q.ph == PH_K) ? PH_KB : PH_K;
        if (commit) begin
            d.mem[buf_a]  = c0;
            d.mem[buf_a1] = c1;
        end
        d.dvld = rv;
        d.dout = rv ? m4 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_K;
        end else begin
            q <= d;
        end
    end

    assign dout     = q.dout;
    assign dout_vld = q.dvld;

    logic rd_cmd;
    assign rd_cmd = rst_n & k_edge & ~rd_n;

    // R2
    rd_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |-> ##4 dout_vld ##1 dout_vld);

    // R9
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rd_cmd, 4) && !$past(rd_cmd, 5)) |-> !dout_vld);

    // R9
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> (dout == '0));
endmodule

// File: tb/qb2_sram_bench.sv
module qb2_sram_bench;
    localparam int AW     = 4;
    localparam int BYTES  = 4;
    localparam int BYTE_W = 9;
    localparam int W      = BYTES * BYTE_W;
    localparam int DEPTH  = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_n = 1'b1;
    logic             wr_n = 1'b1;
    logic [AW-1:0]    addr = '0;
    logic [W-1:0]     din = '0;
    logic [BYTES-1:0] bwe_n = '1;
    logic [W-1:0]     dout;
    logic             dout_vld;

    qb2_sram #(.AW(AW), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_qb2_sram (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .din(din), .bwe_n(bwe_n), .dout(dout), .dout_vld(dout_vld)
    );

    always #4 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    int e = 0;
    logic [W-1:0] model [DEPTH];
    logic         sch_v [8];
    logic [W-1:0] sch_d [8];
    string        sch_t [8];
    bit           prev_rd = 1'b0;
    logic [AW-1:0] prev_ra = '0;
    string        prev_t = "";

    function automatic logic [W-1:0] merge(logic [W-1:0] base, logic [W-1:0] upd,
                                           logic [BYTES-1:0] be_n);
        logic [W-1:0] r = base;
        for (int b = 0; b < BYTES; b++)
            if (!be_n[b]) r[b*BYTE_W +: BYTE_W] = upd[b*BYTE_W +: BYTE_W];
        return r;
    endfunction

    function automatic logic [W-1:0] pat(int a, int s);
        logic [31:0] x = a * 32'h9E37_79B1 ^ s * 32'h0123_4567;
        return {4'(a + s), x};
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic edge_wait();
        @(posedge clk);
        e++;
        @(negedge clk);
    endtask

    task automatic check_out();
        int i = e % 8;
        if (sch_v[i]) begin
            check({sch_t[i], " valid"}, W'(dout_vld), W'(1));
            check({sch_t[i], " data"}, dout, sch_d[i]);
        end else begin
            check("R1 R9 idle valid", W'(dout_vld), W'(0));
            check("R9 idle data", dout, '0);
        end
        sch_v[i] = 1'b0;
    endtask

    // One K/K# pair. Strobes are driven low on every K# half (R1: must be ignored).
    task automatic kcyc(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                        logic [W-1:0] d0, logic [BYTES-1:0] b0,
                        logic [W-1:0] d1, logic [BYTES-1:0] b1, string tag);
        logic [AW-1:0] wa1 = wa + 1'b1;
        logic [AW-1:0] pa1 = prev_ra + 1'b1;
        rd_n = !rd; wr_n = !wr; addr = ra; din = d0; bwe_n = b0;
        edge_wait();
        check_out();
        rd_n = 1'b0; wr_n = 1'b0; addr = wa; din = d1; bwe_n = b1;
        edge_wait();
        if (wr) begin
            model[wa]  = merge(model[wa], d0, b0);
            model[wa1] = merge(model[wa1], d1, b1);
        end
        if (prev_rd) begin
            sch_v[e % 8] = 1'b1; sch_d[e % 8] = model[prev_ra];
            sch_t[e % 8] = {prev_t, " beat0"};
            sch_v[(e + 1) % 8] = 1'b1; sch_d[(e + 1) % 8] = model[pa1];
            sch_t[(e + 1) % 8] = {prev_t, " beat1"};
        end
        check_out();
        prev_rd = rd; prev_ra = ra; prev_t = tag;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) kcyc(0, '0, 0, '0, '0, '1, '0, '1, "");
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        kcyc(1, a, 0, '0, '0, '1, '0, '1, tag);
    endtask

    task automatic wrf(logic [AW-1:0] a, int s, string tag);
        kcyc(0, '0, 1, a, pat(a, s), '0, pat(a + 1, s), '0, tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        for (int i = 0; i < 8; i++) begin sch_v[i] = 1'b0; sch_d[i] = '0; sch_t[i] = ""; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset valid", W'(dout_vld), W'(0));
        check("R10 reset data", dout, '0);

        // R10: cleared array reads as zero, including the wrap word
        rd(0, "R10 cleared"); rd(15, "R10 R3 cleared wrap"); idle(3);

        // R4 fill every word with back-to-back writes; last pair stays posted
        for (int a = 0; a < DEPTH; a += 2) wrf(AW'(a), 1, "R4");
        idle(1);
        // R2 R3 R6: back-to-back read sweep, wrap at the top, buffer forwarding
        for (int a = 0; a < DEPTH; a++) rd(AW'(a), "R2 R3 R6 sweep");
        idle(3);

        // R8: concurrent reads and writes on every K edge
        for (int a = 0; a < DEPTH; a++)
            kcyc(1, AW'(a), 1, AW'(a + 5), pat(a, 2), '0, pat(a, 7), '0, "R8 concurrent");
        idle(3);

        // R5: every byte mask on both beats, read back
        for (int m = 0; m < (1 << BYTES); m++) begin
            kcyc(0, '0, 1, 4'd4, pat(m, 3), BYTES'(m), pat(m, 4), BYTES'(~m), "R5");
            rd(4, "R5 mask sweep");
        end
        kcyc(0, '0, 1, 4'd4, pat(9, 9), '1, pat(9, 9), '1, "R5");
        rd(4, "R5 abort both beats");
        wrf(12, 5, "R6"); rd(4, "R5 R6 abort after commit");
        idle(3);

        // R7: read one K edge before a write to the same or overlapping words
        rd(8, "R7 read-then-write same"); wrf(8, 11, "R7"); idle(3);
        rd(9, "R7 read-then-write beat1 in flight"); wrf(8, 12, "R7"); idle(3);
        rd(7, "R7 read-then-write overlap"); wrf(8, 13, "R7"); idle(3);
        kcyc(1, 4'd8, 1, 4'd8, pat(1, 14), 4'b0101, pat(2, 14), 4'b1010, "R7 same edge");
        idle(3);
        rd(8, "R7 R5 masked in flight"); 
        kcyc(0, '0, 1, 4'd8, pat(3, 15), 4'b0011, pat(4, 15), 4'b1100, "R7");
        idle(3);

        // R3: write burst wrapping from the last word to word 0
        wrf(15, 20, "R3"); rd(15, "R3 write wrap"); wrf(2, 21, "R6"); rd(15, "R3 R6 wrap committed");
        idle(3);

        // R8 R9: gaps between reads, bursts complete across idle K edges
        rd(3, "R8 R9 gap"); idle(1); rd(6, "R8 R9 gap"); idle(2); rd(10, "R8 R9 gap");
        idle(4);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_run++; n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule